// File: doc/BRIEF.md
# Linked-list Turing machine stepper

This block runs a Turing machine whose program and tape live in a word-addressed RAM as chains of two-word cells. A cell sits at an even address: its first word carries an element and its second word links to the rest of the chain. One fixed address (`NIL_ADDR`) marks the end of every chain. A machine state is a chain of transitions. Each transition is itself a chain of four elements: trigger symbol, replacement symbol, direction, and the head of the target state's chain. Symbols are the addresses of symbol cells and are compared by address alone.

The tape is a current cell plus two stacks of cells. The left stack holds the cells to the left of the head, nearest first. The right stack holds the cells to the right, and is initially the tail of the tape chain. After a `start` pulse the sequencer tries transitions one at a time. It makes one memory access per clock cycle and keeps going until no transition applies. Another agent writes the machine image into the RAM before `start`. The RAM has single-cycle read latency: data for an address issued in one cycle is presented on `mem_rdata` in the next.

Top module: `cons_tm_stepper`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `busy`, `halted` and `fault` are 0, `step_count` is 0 and `mem_we` is 0.
- R2: A `start` pulse while idle loads the pointers and clears `halted`, `fault` and `step_count`. The loaded pointers are: current transition pointer from `cfg_state`, current cell from `cfg_tape0`, left stack empty (`NIL_ADDR`), right stack from `cfg_tape1`. `busy` is 1 from the next cycle until the run ends. A `start` pulse while `busy` is 1 has no effect on the run.
- R3: A transition matches when word 0 of the current cell equals the transition's trigger address; the contents of symbol cells are never read. On a match, word 0 of the current cell is overwritten with the replacement symbol address.
- R4: On a mismatch the current cell is left unchanged and the transition pointer moves to word 1 of the current list cell, which is the next transition of the same state.
- R5: A match with direction 1 (right) does two things. It pushes the current cell onto the left stack: word 1 of the cell receives the old left head. It then pops the new current cell from the right stack; the right stack becomes word 1 of the popped cell.
- R6: A match with direction 0 (left) first pushes the current cell onto the right stack, storing the old right head in its word 1. It then pops the new current cell from the left stack. After the move, the transition pointer becomes the target state's chain.
- R7: When the transition pointer equals `NIL_ADDR`, the run ends with `halted`=1 and `fault`=0. The pointer reaches `NIL_ADDR` when no transition of the state matched or when the target state has none. `halted` then stays 1 until the next accepted `start`.
- R8: A matched left move with an empty left stack ends the run with `fault`=1 and `halted`=1. The symbol is still written, but no link word or stack is changed.
- R9: `step_count` increases by exactly 1 for each completed matched transition, and the faulting one is not counted.
- R10: At most one of `mem_re` and `mem_we` is 1 in a cycle, and neither is 1 while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| cfg_state | input | W | Head of the start state's transition chain |
| cfg_tape0 | input | W | First tape cell |
| cfg_tape1 | input | W | Second tape cell (initial right stack) |
| mem_addr | output | W | RAM word address |
| mem_re | output | 1 | RAM read strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | W | RAM write data |
| mem_rdata | input | W | RAM read data, one cycle after the read |
| busy | output | 1 | Run in progress |
| halted | output | 1 | Last run ended |
| fault | output | 1 | Last run ended by a left move off the tape |
| step_count | output | CNT_W | Matched transitions in the current or last run |

## Verification
Several properties are checked on every cycle:
- `busy` and `halted` are never both 1;
- a fault always comes with a halt;
- `halted` persists until a start;
- the step counter moves by at most one per cycle during a run;
- memory strobes are exclusive and only occur while busy;
- a run only begins after a start.

Only the bench scenarios can show the following, by inspecting the RAM after each run:
- the rewritten symbols and the fall-through on a mismatch;
- the stack links left by right and left moves;
- the step totals;
- the stop on an empty target state;
- the off-tape fault.

// File: rtl/tm_pkg.sv
// Shared types for the linked-list Turing machine stepper.
// Assumes: nothing beyond a 4-bit encoding for the sequencer state.
package tm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TRIG,
        ST_SYM,
        ST_CMP,
        ST_NEXT,
        ST_NEW1,
        ST_NEW2,
        ST_DIR1,
        ST_DIR2,
        ST_DIR3,
        ST_TGT1,
        ST_TGT2,
        ST_POP1,
        ST_POP2
    } seq_state_t;

endpackage

// File: rtl/tm_step_ctr.sv
// Counts matched transitions of a run.
// Assumes: clr and inc never matter in the same cycle (clr wins); the count saturates.
module tm_step_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: clear on start, add one per completed step, hold at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tm_seq.sv
// Sequencer that walks transition chains and tape stacks, one RAM access per cycle.
// Assumes: cells start at even addresses, RAM read data arrives one cycle after
// the read, and the right stack never runs empty (the tape chain is unbounded).
module tm_seq
    import tm_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] NIL_ADDR = W'(2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] cfg_state,
    input  logic [W-1:0] cfg_tape0,
    input  logic [W-1:0] cfg_tape1,
    output logic [W-1:0] mem_addr,
    output logic         mem_re,
    output logic         mem_we,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         busy,
    output logic         halted,
    output logic         fault,
    output logic         step_clr,
    output logic         step_inc
);

    seq_state_t   state_q;
    logic [W-1:0] t_q;      // current transition list cell
    logic [W-1:0] s_q;      // current tape cell
    logic [W-1:0] l_q;      // left stack head
    logic [W-1:0] r_q;      // right stack head
    logic [W-1:0] x_q;      // first cell of the transition record
    logic [W-1:0] trig_q;   // trigger symbol address
    logic [W-1:0] c2_q;     // second record cell
    logic [W-1:0] c3_q;     // third record cell
    logic [W-1:0] tgt_q;    // target state chain
    logic         dir_q;    // 1 = right
    logic         halted_q;
    logic         fault_q;
    logic         left_empty;

    // Address of word 1 of the cell holding a.
    function automatic logic [W-1:0] link_of(input logic [W-1:0] a);
        return {a[W-1:1], 1'b1};
    endfunction

    assign left_empty = (l_q == NIL_ADDR);
    assign busy       = (state_q != ST_IDLE);
    assign halted     = halted_q;
    assign fault      = fault_q;
    assign step_clr   = (state_q == ST_IDLE) && start;
    assign step_inc   = (state_q == ST_POP2);

    // Purpose: drive the single RAM access of the current cycle.
    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state_q)
            ST_FETCH: begin
                if (t_q != NIL_ADDR) begin
                    mem_re   = 1'b1;
                    mem_addr = t_q;
                end
            end
            ST_TRIG: begin
                mem_re   = 1'b1;
                mem_addr = mem_rdata;
            end
            ST_SYM: begin
                mem_re   = 1'b1;
                mem_addr = s_q;
            end
            ST_CMP: begin
                mem_re   = 1'b1;
                mem_addr = (mem_rdata == trig_q) ? link_of(x_q) : link_of(t_q);
            end
            ST_NEW1: begin
                mem_re   = 1'b1;
                mem_addr = mem_rdata;
            end
            ST_NEW2: begin
                mem_we    = 1'b1;
                mem_addr  = s_q;
                mem_wdata = mem_rdata;
            end
            ST_DIR1: begin
                mem_re   = 1'b1;
                mem_addr = link_of(c2_q);
            end
            ST_DIR2: begin
                mem_re   = 1'b1;
                mem_addr = mem_rdata;
            end
            ST_DIR3: begin
                mem_re   = 1'b1;
                mem_addr = link_of(c3_q);
            end
            ST_TGT1: begin
                mem_re   = 1'b1;
                mem_addr = mem_rdata;
            end
            ST_TGT2: begin
                if (dir_q || !left_empty) begin
                    mem_we    = 1'b1;
                    mem_addr  = link_of(s_q);
                    mem_wdata = dir_q ? l_q : r_q;
                end
            end
            ST_POP1: begin
                mem_re   = 1'b1;
                mem_addr = dir_q ? link_of(r_q) : link_of(l_q);
            end
            default: begin
                mem_re = 1'b0;
            end
        endcase
    end

    // Purpose: advance the step sequence and update the tape and table pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            t_q      <= NIL_ADDR;
            s_q      <= '0;
            l_q      <= NIL_ADDR;
            r_q      <= '0;
            x_q      <= '0;
            trig_q   <= '0;
            c2_q     <= '0;
            c3_q     <= '0;
            tgt_q    <= '0;
            dir_q    <= 1'b0;
            halted_q <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        t_q      <= cfg_state;
                        s_q      <= cfg_tape0;
                        l_q      <= NIL_ADDR;
                        r_q      <= cfg_tape1;
                        halted_q <= 1'b0;
                        fault_q  <= 1'b0;
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (t_q == NIL_ADDR) begin
                        halted_q <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_TRIG;
                    end
                end
                ST_TRIG: begin
                    x_q     <= mem_rdata;
                    state_q <= ST_SYM;
                end
                ST_SYM: begin
                    trig_q  <= mem_rdata;
                    state_q <= ST_CMP;
                end
                ST_CMP: begin
                    state_q <= (mem_rdata == trig_q) ? ST_NEW1 : ST_NEXT;
                end
                ST_NEXT: begin
                    t_q     <= mem_rdata;
                    state_q <= ST_FETCH;
                end
                ST_NEW1: begin
                    c2_q    <= mem_rdata;
                    state_q <= ST_NEW2;
                end
                ST_NEW2: begin
                    state_q <= ST_DIR1;
                end
                ST_DIR1: begin
                    state_q <= ST_DIR2;
                end
                ST_DIR2: begin
                    c3_q    <= mem_rdata;
                    state_q <= ST_DIR3;
                end
                ST_DIR3: begin
                    dir_q   <= mem_rdata[0];
                    state_q <= ST_TGT1;
                end
                ST_TGT1: begin
                    state_q <= ST_TGT2;
                end
                ST_TGT2: begin
                    tgt_q <= mem_rdata;
                    if (!dir_q && left_empty) begin
                        fault_q  <= 1'b1;
                        halted_q <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_POP1;
                    end
                end
                ST_POP1: begin
                    if (dir_q) begin
                        l_q <= s_q;
                        s_q <= r_q;
                    end else begin
                        r_q <= s_q;
                        s_q <= l_q;
                    end
                    state_q <= ST_POP2;
                end
                ST_POP2: begin
                    if (dir_q) begin
                        r_q <= mem_rdata;
                    end else begin
                        l_q <= mem_rdata;
                    end
                    t_q     <= tgt_q;
                    state_q <= ST_FETCH;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cons_tm_stepper.sv
// Top of the linked-list Turing machine stepper: sequencer plus step counter.
// Assumes: an external single-port RAM with one-cycle read latency holds the image.
module cons_tm_stepper #(
    parameter int           W        = 16,
    parameter int           CNT_W    = 16,
    parameter logic [W-1:0] NIL_ADDR = W'(2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     cfg_state,
    input  logic [W-1:0]     cfg_tape0,
    input  logic [W-1:0]     cfg_tape1,
    output logic [W-1:0]     mem_addr,
    output logic             mem_re,
    output logic             mem_we,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    output logic             busy,
    output logic             halted,
    output logic             fault,
    output logic [CNT_W-1:0] step_count
);

    logic step_clr;
    logic step_inc;

    tm_seq #(
        .W        (W),
        .NIL_ADDR (NIL_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_state (cfg_state),
        .cfg_tape0 (cfg_tape0),
        .cfg_tape1 (cfg_tape1),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .halted    (halted),
        .fault     (fault),
        .step_clr  (step_clr),
        .step_inc  (step_inc)
    );

    tm_step_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .inc   (step_inc),
        .count (step_count)
    );

endmodule

// File: rtl/tm_stepper_chk.sv
// Checker for cons_tm_stepper, attached by bind below.
// Assumes: observes only top-level ports.
module tm_stepper_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mem_re,
    input logic             mem_we,
    input logic             busy,
    input logic             halted,
    input logic             fault,
    input logic [CNT_W-1:0] step_count
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !halted && !fault && (step_count == '0) && !mem_we));

    assert_run_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_busy_halt_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && halted));

    assert_halt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> halted);

    assert_fault_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> halted);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
        ((step_count == $past(step_count)) || (step_count == $past(step_count) + CNT_W'(1))));

    assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(step_count));

    assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    assert_mem_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> busy);

endmodule

bind cons_tm_stepper tm_stepper_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .busy       (busy),
    .halted     (halted),
    .fault      (fault),
    .step_count (step_count)
);

// File: tb/sim_cons_tm_stepper.sv
`timescale 1ns/1ps
module sim_cons_tm_stepper;

    localparam logic [15:0] NIL  = 16'd2;
    localparam logic [15:0] BLK  = 16'd4;
    localparam logic [15:0] SY2  = 16'd6;
    localparam logic [15:0] SY3  = 16'd8;
    localparam logic [15:0] TAPE = 16'd512;
    localparam int          TCELLS = 32;
    // n ones on tape, expected matched steps for the unary incrementer
    localparam int VEC [4][2] = '{'{0, 1}, '{3, 4}, '{6, 7}, '{1, 2}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_state = NIL;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_re, mem_we, busy, halted, fault;
    logic [15:0] step_count;

    logic [15:0] ram [0:1023];
    logic        tb_we = 1'b0;
    logic [15:0] tb_a = '0;
    logic [15:0] tb_d = '0;

    int checks = 0;
    int errors = 0;
    int cyc;

    always #2.5 clk = ~clk;

    cons_tm_stepper u0 (
        .clk (clk), .rst_n (rst_n), .start (start),
        .cfg_state (cfg_state), .cfg_tape0 (TAPE), .cfg_tape1 (TAPE + 16'd2),
        .mem_addr (mem_addr), .mem_re (mem_re), .mem_we (mem_we),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .busy (busy), .halted (halted), .fault (fault), .step_count (step_count)
    );

    // RAM model: one-cycle read latency; bench loads through the same port.
    always_ff @(posedge clk) begin
        if (tb_we) ram[tb_a[9:0]] <= tb_d;
        else if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr[9:0]];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [15:0] lc(input int i);
        return 16'(32 + 2 * i);
    endfunction

    // transition i: list cell lc(i) -> record at 128+8i, chained to nxt
    task automatic trans(input int i, input logic [15:0] trig, input logic [15:0] nsym,
                         input logic [15:0] dir, input logic [15:0] tgt, input logic [15:0] nxt);
        logic [15:0] rb;
        rb = 16'(128 + 8 * i);
        poke(lc(i), rb);        poke(lc(i) + 16'd1, nxt);
        poke(rb, trig);         poke(rb + 16'd1, rb + 16'd2);
        poke(rb + 16'd2, nsym); poke(rb + 16'd3, rb + 16'd4);
        poke(rb + 16'd4, dir);  poke(rb + 16'd5, rb + 16'd6);
        poke(rb + 16'd6, tgt);  poke(rb + 16'd7, NIL);
    endtask

    task automatic build_tape(input int ones);
        for (int k = 0; k < TCELLS; k++) begin
            poke(16'(TAPE + 2 * k), (k < ones) ? SY2 : BLK);
            poke(16'(TAPE + 2 * k + 1), 16'(TAPE + 2 * k + 2));
        end
    endtask

    function automatic logic [15:0] sym(input int k);
        return ram[10'(TAPE + 2 * k)];
    endfunction

    function automatic logic [15:0] lnk(input int k);
        return ram[10'(TAPE + 2 * k + 1)];
    endfunction

    task automatic pulse_start(input logic [15:0] st);
        @(negedge clk);
        cfg_state = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(halted, {tag, " run ends"}, int'(halted), 1);
    endtask

    task automatic load_incr();
        trans(0, SY2, SY2, 16'd1, lc(0), lc(1));
        trans(1, BLK, SY2, 16'd1, NIL, NIL);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !halted && !fault, "R1 flags after reset", int'({busy, halted, fault}), 0);
        check(step_count == 0, "R1 count after reset", int'(step_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R7 R9: unary incrementer from the vector table
        load_incr();
        for (int v = 0; v < 4; v++) begin
            build_tape(VEC[v][0]);
            pulse_start(lc(0));
            check(busy && !halted, "R2 busy after start", int'({busy, halted}), 2);
            wait_halt("R7 incr");
            check(!fault, "R7 incr no fault", int'(fault), 0);
            check(int'(step_count) == VEC[v][1], "R9 incr steps", int'(step_count), VEC[v][1]);
            for (int k = 0; k <= VEC[v][0]; k++)
                check(sym(k) == SY2, "R3 incr symbol written", int'(sym(k)), int'(SY2));
            check(sym(VEC[v][0] + 1) == BLK, "R5 cell past head untouched",
                  int'(sym(VEC[v][0] + 1)), int'(BLK));
        end

        // R7: halted held while idle
        repeat (20) @(negedge clk);
        check(halted, "R7 halted held", int'(halted), 1);

        // R3 R4 R7: no transition matches, cell unchanged
        trans(0, SY2, SY3, 16'd1, lc(0), NIL);
        build_tape(0);
        pulse_start(lc(0));
        check(!halted, "R2 start clears halted", int'(halted), 0);
        wait_halt("R4 nomatch");
        check(step_count == 0, "R4 nomatch steps", int'(step_count), 0);
        check(sym(0) == BLK, "R4 mismatch leaves cell", int'(sym(0)), int'(BLK));
        check(!fault, "R7 nomatch no fault", int'(fault), 0);

        // R7: empty start state halts at once
        pulse_start(NIL);
        wait_halt("R7 empty start");
        check(step_count == 0 && !fault, "R7 empty start", int'(step_count), 0);

        // R5 R6 R4: right, left, mismatch fall-through, right, right
        trans(0, BLK, SY2, 16'd1, lc(1), NIL);
        trans(1, BLK, SY3, 16'd0, lc(2), NIL);
        trans(2, SY3, SY3, 16'd1, NIL, lc(3));
        trans(3, SY2, SY2, 16'd1, lc(4), NIL);
        trans(4, SY3, SY3, 16'd1, NIL, NIL);
        build_tape(0);
        pulse_start(lc(0));
        wait_halt("R6 walk");
        check(step_count == 4, "R6 walk steps", int'(step_count), 4);
        check(sym(0) == SY2, "R6 walk cell0", int'(sym(0)), int'(SY2));
        check(sym(1) == SY3, "R6 left move wrote cell1", int'(sym(1)), int'(SY3));
        check(sym(2) == BLK, "R6 walk cell2", int'(sym(2)), int'(BLK));
        check(lnk(1) == TAPE, "R5 push links left head", int'(lnk(1)), int'(TAPE));
        check(lnk(0) == NIL, "R6 left pop emptied stack", int'(lnk(0)), int'(NIL));
        check(lnk(2) == 16'(TAPE + 6), "R5 right stack link intact", int'(lnk(2)), int'(TAPE + 6));

        // R8: left move off the first cell
        trans(0, BLK, SY2, 16'd1, lc(2), lc(1));
        trans(1, SY2, SY2, 16'd0, lc(2), NIL);
        trans(2, BLK, SY2, 16'd0, lc(0), lc(3));
        trans(3, SY2, SY2, 16'd1, NIL, NIL);
        build_tape(0);
        pulse_start(lc(0));
        wait_halt("R8 fault");
        check(fault, "R8 fault raised", int'(fault), 1);
        check(step_count == 2, "R9 faulting step not counted", int'(step_count), 2);
        check(sym(0) == SY2 && sym(1) == SY2, "R8 tape symbols", int'(sym(1)), int'(SY2));
        check(lnk(0) == NIL, "R8 no link written", int'(lnk(0)), int'(NIL));

        // R2: start during a run is ignored
        load_incr();
        build_tape(6);
        pulse_start(lc(0));
        repeat (10) @(negedge clk);
        pulse_start(NIL);
        wait_halt("R2 ignore");
        check(step_count == 7 && !fault, "R2 start while busy ignored", int'(step_count), 7);

        // R1: reset during a run
        build_tape(6);
        pulse_start(lc(0));
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !halted && !fault && step_count == 0, "R1 reset mid-run",
              int'({busy, halted, fault}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule